// File: doc/BRIEF.md
# Upstream Message Mailbox with Ownership Semaphore

This block carries a message from one of several on-chip processors up to a JTAG debugger. Processors share one transmit link. A processor first reads a claim register. The read either grants the link to that processor or tells it the link is taken. The owner then fills an eight-word buffer, writes the message length in words, and sets a notify bit. Setting that bit drives the debugger notification pin low.

The debugger reads the buffer and the length through a TAP-side read port. The TAP shift logic that does this lives outside the block. When the debugger finishes, the TAP side pulses an end-of-transfer strobe. The strobe releases the claim and returns the notification pin high. The pin therefore stays low from the notify write until the transfer is done.

Every bus access carries a master ID. Only the current owner can change the buffer, the length or the notify state. Writes from any other master have no effect.

Top module: `upmsg_mailbox`

## Requirements
- R1: After reset, notify_n is 1, tap_len is 0, every buffer word reads 0, and the link is free, so the first claim read returns 1.
- R2: A bus read of the claim address (DEPTH, 8 by default) returns 1 in bus_rdata bit 0 when the link is free, and the reading master becomes owner on that edge. While the link is owned, the same read returns 0 to every master, including the owner.
- R3: An owner write to addresses 0 to DEPTH-1 stores bus_wdata in that buffer word, and the word appears on tap_rdata from the next cycle.
- R4: An owner write to the length address (DEPTH+1, 9 by default) sets tap_len from the next cycle. A value above DEPTH is stored as DEPTH.
- R5: An owner write to the notify address (DEPTH+2, 10 by default) with bus_wdata bit 0 set drives notify_n to 0 from the next cycle. notify_n stays 0 until tap_done. A write there with bit 0 clear has no effect.
- R6: Writes from a master other than the owner, and any write while the link is free, leave the buffer, tap_len and notify_n unchanged.
- R7: A tap_done pulse while the link is owned releases the link and returns notify_n to 1 from the next cycle. The buffer and tap_len keep their values. If a notify write falls in the same cycle as tap_done, tap_done wins.
- R8: If a claim read and tap_done fall in the same cycle while the link is owned, the read returns 0 and the link is free from the next cycle.
- R9: A bus read of addresses 0 to DEPTH-1 returns that buffer word in the same cycle, to any master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_mid | input | ID_W | ID of the accessing master |
| bus_rdata | output | DATA_W | Read data, combinational |
| tap_raddr | input | IDX_W | Buffer word selected by the TAP side |
| tap_rdata | output | DATA_W | Selected buffer word |
| tap_len | output | LEN_W | Stored message length in words |
| tap_done | input | 1 | End-of-transfer strobe from the TAP side |
| notify_n | output | 1 | Active-low debugger notification |

## Verification
The end-of-transfer strobe can land in the same cycle as a bus access that depends on ownership. The two cases are a claim read and an owner's notify write.

The bench provokes both cases directly. It raises tap_done in the same cycle as a third master's claim read while the link is held. The read must return 0, and a claim on the following cycle must return 1. It then has the new owner write the notify bit in the same cycle as tap_done. notify_n must stay high afterwards, because the release takes priority.

// File: rtl/upmsg_pkg.sv
package upmsg_pkg;

   // Register classes seen on the peripheral bus.
   typedef enum logic [2:0] {
      RSEL_NONE = 3'd0,
      RSEL_BUF  = 3'd1,
      RSEL_SEMA = 3'd2,
      RSEL_LEN  = 3'd3,
      RSEL_NOTE = 3'd4
   } reg_sel_e;

   // Bits needed to hold a count from 0 up to n.
   function automatic int cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/upmsg_sema.sv
module upmsg_sema #(
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            claim_rd,
   input  logic            release_req,
   input  logic [ID_W-1:0] req_mid,
   output logic            owned,
   output logic [ID_W-1:0] owner,
   output logic            grant
);

   logic            owned_q;
   logic [ID_W-1:0] owner_q;

   // The claim succeeds only when nobody holds the link.
   assign grant = claim_rd & ~owned_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owned_q <= 1'b0;
         owner_q <= '0;
      end else begin
         if (release_req)
            owned_q <= 1'b0;
         if (grant) begin
            owned_q <= 1'b1;
            owner_q <= req_mid;
         end
      end
   end

   assign owned = owned_q;
   assign owner = owner_q;

endmodule

// File: rtl/upmsg_store.sv
module upmsg_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LEN_W = upmsg_pkg::cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic [DATA_W-1:0] word_data,
   input  logic              len_we,
   input  logic [DATA_W-1:0] len_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [LEN_W-1:0]  len
);

   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

   logic [DATA_W-1:0] words [DEPTH];
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_sat;

   // One register per buffer word.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[gi] <= '0;
         else if (word_we && (word_idx == IDX_W'(gi)))
            words[gi] <= word_data;
      end
   end

   // Clamp the length to the buffer depth.
   if (DATA_W > LEN_W) begin : g_len_wide
      always_comb begin
         if (len_data > DATA_W'(DEPTH))
            len_sat = LEN_MAX;
         else
            len_sat = len_data[LEN_W-1:0];
      end
   end else begin : g_len_narrow
      always_comb begin
         if (LEN_W'(len_data) > LEN_MAX)
            len_sat = LEN_MAX;
         else
            len_sat = LEN_W'(len_data);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (len_we)
         len_q <= len_sat;
   end

   assign rd_data_a = words[rd_idx_a];
   assign rd_data_b = words[rd_idx_b];
   assign len       = len_q;

endmodule

// File: rtl/upmsg_notify.sv
module upmsg_notify (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic notify_n
);

   logic pend_q;

   // The clear request has priority over a set in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (clr_req)
         pend_q <= 1'b0;
      else if (set_req)
         pend_q <= 1'b1;
   end

   assign notify_n = ~pend_q;

endmodule

// File: rtl/upmsg_mailbox.sv
module upmsg_mailbox #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   parameter int ID_W   = 2,
   parameter int ADDR_W = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int LEN_W = upmsg_pkg::cnt_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ID_W-1:0]   bus_mid,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IDX_W-1:0]  tap_raddr,
   output logic [DATA_W-1:0] tap_rdata,
   output logic [LEN_W-1:0]  tap_len,
   input  logic              tap_done,
   output logic              notify_n
);
   import upmsg_pkg::*;

   // Elaboration-time parameter checks.
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("upmsg_mailbox: DEPTH must be a power of two, at least 2");
   end
   if (ID_W < 1) begin : g_bad_id
      $error("upmsg_mailbox: ID_W must be at least 1");
   end
   if ((2 ** ADDR_W) < DEPTH + 3) begin : g_bad_addr
      $error("upmsg_mailbox: ADDR_W too small for the register map");
   end
   if (DATA_W < LEN_W) begin : g_bad_data
      $error("upmsg_mailbox: DATA_W must hold the length field");
   end

   // The control registers sit just above the buffer words.
   localparam logic [ADDR_W-1:0] SEMA_A = ADDR_W'(DEPTH);
   localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(DEPTH + 1);
   localparam logic [ADDR_W-1:0] NOTE_A = ADDR_W'(DEPTH + 2);

   reg_sel_e          rsel;
   logic              claim_rd;
   logic              sem_owned;
   logic [ID_W-1:0]   sem_owner;
   logic              sem_grant;
   logic              own_wr;
   logic [DATA_W-1:0] buf_bus_word;

   always_comb begin
      if (bus_addr < SEMA_A)
         rsel = RSEL_BUF;
      else if (bus_addr == SEMA_A)
         rsel = RSEL_SEMA;
      else if (bus_addr == LEN_A)
         rsel = RSEL_LEN;
      else if (bus_addr == NOTE_A)
         rsel = RSEL_NOTE;
      else
         rsel = RSEL_NONE;
   end

   assign claim_rd = bus_sel & ~bus_wr & (rsel == RSEL_SEMA);
   assign own_wr   = bus_sel & bus_wr & sem_owned & (bus_mid == sem_owner);

   upmsg_sema #(.ID_W(ID_W)) u_sema (
      .clk         (clk),
      .rst_n       (rst_n),
      .claim_rd    (claim_rd),
      .release_req (tap_done),
      .req_mid     (bus_mid),
      .owned       (sem_owned),
      .owner       (sem_owner),
      .grant       (sem_grant)
   );

   upmsg_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we   (own_wr && (rsel == RSEL_BUF)),
      .word_idx  (bus_addr[IDX_W-1:0]),
      .word_data (bus_wdata),
      .len_we    (own_wr && (rsel == RSEL_LEN)),
      .len_data  (bus_wdata),
      .rd_idx_a  (bus_addr[IDX_W-1:0]),
      .rd_data_a (buf_bus_word),
      .rd_idx_b  (tap_raddr),
      .rd_data_b (tap_rdata),
      .len       (tap_len)
   );

   upmsg_notify u_notify (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (own_wr && (rsel == RSEL_NOTE) && bus_wdata[0]),
      .clr_req  (tap_done),
      .notify_n (notify_n)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (rsel)
            RSEL_BUF:  bus_rdata = buf_bus_word;
            RSEL_SEMA: bus_rdata = DATA_W'(sem_grant);
            default:   bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/upmsg_mailbox_chk.sv
module upmsg_mailbox_chk #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   parameter int ID_W   = 2,
   parameter int ADDR_W = 4,
   parameter int LEN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [ID_W-1:0]   bus_mid,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [LEN_W-1:0]  tap_len,
   input logic              tap_done,
   input logic              notify_n,
   input logic              sem_owned,
   input logic [ID_W-1:0]   sem_owner
);

   localparam logic [ADDR_W-1:0] SEMA_A = ADDR_W'(DEPTH);
   localparam logic [ADDR_W-1:0] NOTE_A = ADDR_W'(DEPTH + 2);

   logic claim_c;
   logic owner_c;
   assign claim_c = bus_sel && !bus_wr && (bus_addr == SEMA_A);
   assign owner_c = sem_owned && (bus_mid == sem_owner);

   // R2
   claim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_c && sem_owned) |-> (bus_rdata == '0));

   // R2
   claim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_c && !sem_owned) |=> (sem_owned && sem_owner == $past(bus_mid)));

   // R4
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_len <= LEN_W'(DEPTH));

   // R5
   notify_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == NOTE_A && bus_wdata[0] && owner_c && !tap_done)
      |=> !notify_n);

   // R5
   notify_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !notify_n |-> sem_owned);

   // R6
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !owner_c && !tap_done) |=> ($stable(tap_len) && $stable(notify_n)));

   // R7
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_done && sem_owned) |=> (notify_n && !sem_owned));

endmodule

bind upmsg_mailbox upmsg_mailbox_chk #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_mid   (bus_mid),
   .bus_rdata (bus_rdata),
   .tap_len   (tap_len),
   .tap_done  (tap_done),
   .notify_n  (notify_n),
   .sem_owned (sem_owned),
   .sem_owner (sem_owner)
);

// File: tb/upmsg_mailbox_test.sv
module upmsg_mailbox_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [1:0]  bus_mid = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  tap_raddr = '0;
   logic [15:0] tap_rdata;
   logic [3:0]  tap_len;
   logic        tap_done = 1'b0;
   logic        notify_n;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   upmsg_mailbox uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
      .bus_rdata(bus_rdata), .tap_raddr(tap_raddr), .tap_rdata(tap_rdata),
      .tap_len(tap_len), .tap_done(tap_done), .notify_n(notify_n)
   );

   // Kinds: 0 bus read+check, 1 bus write, 2 tap_done, 3 tap word check,
   // 4 length check, 5 notify_n check.
   // Fields: {kind[3], req[4], mid[2], addr[4], data[16], exp[16]}
   localparam int NV = 30;
   localparam logic [44:0] VEC [NV] = '{
      {3'd0, 4'd2, 2'd1, 4'd8,  16'h0000, 16'h0001}, // R2 claim by 1
      {3'd0, 4'd2, 2'd2, 4'd8,  16'h0000, 16'h0000}, // R2 busy
      {3'd0, 4'd2, 2'd1, 4'd8,  16'h0000, 16'h0000}, // R2 owner too
      {3'd1, 4'd0, 2'd1, 4'd0,  16'hA5A5, 16'h0000},
      {3'd1, 4'd0, 2'd1, 4'd7,  16'h1234, 16'h0000},
      {3'd1, 4'd0, 2'd2, 4'd0,  16'hFFFF, 16'h0000},
      {3'd3, 4'd6, 2'd0, 4'd0,  16'h0000, 16'hA5A5}, // R6
      {3'd3, 4'd3, 2'd0, 4'd7,  16'h0000, 16'h1234}, // R3
      {3'd0, 4'd9, 2'd3, 4'd7,  16'h0000, 16'h1234}, // R9
      {3'd1, 4'd0, 2'd1, 4'd9,  16'h0005, 16'h0000},
      {3'd1, 4'd0, 2'd2, 4'd9,  16'h0002, 16'h0000},
      {3'd4, 4'd6, 2'd0, 4'd0,  16'h0000, 16'h0005}, // R6
      {3'd1, 4'd0, 2'd1, 4'd9,  16'h000F, 16'h0000},
      {3'd4, 4'd4, 2'd0, 4'd0,  16'h0000, 16'h0008}, // R4 saturate
      {3'd1, 4'd0, 2'd1, 4'd10, 16'h0000, 16'h0000},
      {3'd5, 4'd5, 2'd0, 4'd0,  16'h0000, 16'h0001}, // R5 bit0 clear
      {3'd1, 4'd0, 2'd2, 4'd10, 16'h0001, 16'h0000},
      {3'd5, 4'd6, 2'd0, 4'd0,  16'h0000, 16'h0001}, // R6
      {3'd1, 4'd0, 2'd1, 4'd10, 16'h0001, 16'h0000},
      {3'd5, 4'd5, 2'd0, 4'd0,  16'h0000, 16'h0000}, // R5 low
      {3'd5, 4'd5, 2'd0, 4'd0,  16'h0000, 16'h0000}, // R5 held
      {3'd2, 4'd0, 2'd0, 4'd0,  16'h0000, 16'h0000},
      {3'd5, 4'd7, 2'd0, 4'd0,  16'h0000, 16'h0001}, // R7 released
      {3'd4, 4'd7, 2'd0, 4'd0,  16'h0000, 16'h0008}, // R7 len kept
      {3'd3, 4'd7, 2'd0, 4'd0,  16'h0000, 16'hA5A5}, // R7 word kept
      {3'd1, 4'd0, 2'd1, 4'd0,  16'h0000, 16'h0000},
      {3'd3, 4'd6, 2'd0, 4'd0,  16'h0000, 16'hA5A5}, // R6 free link
      {3'd0, 4'd7, 2'd2, 4'd8,  16'h0000, 16'h0001}, // R7 free again
      {3'd1, 4'd0, 2'd2, 4'd3,  16'hBEEF, 16'h0000},
      {3'd3, 4'd3, 2'd0, 4'd3,  16'h0000, 16'hBEEF}  // R3
   };

   task automatic check(input int req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      bus_sel = 1'b0; bus_wr = 1'b0; tap_done = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      check(1, "reset notify_n", 16'(notify_n), 16'h0001);
      check(1, "reset tap_len", 16'(tap_len), 16'h0000);
      tap_raddr = 3'd5;
      #1;
      check(1, "reset word", tap_rdata, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [2:0]  k;
         logic [3:0]  rq;
         logic [15:0] ev;
         @(negedge clk);
         idle();
         k  = VEC[i][44:42];
         rq = VEC[i][41:38];
         ev = VEC[i][15:0];
         bus_mid   = VEC[i][37:36];
         bus_addr  = VEC[i][35:32];
         bus_wdata = VEC[i][31:16];
         tap_raddr = VEC[i][34:32];
         case (k)
            3'd0: begin bus_sel = 1'b1; bus_wr = 1'b0; end
            3'd1: begin bus_sel = 1'b1; bus_wr = 1'b1; end
            3'd2: tap_done = 1'b1;
            default: ;
         endcase
         #2;
         case (k)
            3'd0: check(int'(rq), $sformatf("vec %0d bus read", i), bus_rdata, ev);
            3'd3: check(int'(rq), $sformatf("vec %0d tap word", i), tap_rdata, ev);
            3'd4: check(int'(rq), $sformatf("vec %0d length", i), 16'(tap_len), ev);
            3'd5: check(int'(rq), $sformatf("vec %0d notify_n", i), 16'(notify_n), ev);
            default: ;
         endcase
      end

      // R8: claim read by master 3 collides with tap_done while 2 owns.
      @(negedge clk);
      idle();
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd8; bus_mid = 2'd3; tap_done = 1'b1;
      #2;
      check(8, "claim during done", bus_rdata, 16'h0000);
      @(negedge clk);
      idle();
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd8; bus_mid = 2'd3;
      #2;
      check(8, "claim after done", bus_rdata, 16'h0001);

      // R7: notify write by owner 3 in the same cycle as tap_done.
      @(negedge clk);
      idle();
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd10; bus_wdata = 16'h0001;
      bus_mid = 2'd3; tap_done = 1'b1;
      @(negedge clk);
      idle();
      #2;
      check(7, "notify vs done", 16'(notify_n), 16'h0001);

      // R1: reset mid-run clears length and buffer.
      rst_n = 1'b0;
      tap_raddr = 3'd3;
      #2;
      check(1, "rerun tap_len", 16'(tap_len), 16'h0000);
      check(1, "rerun word", tap_rdata, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd8; bus_mid = 2'd0;
      #2;
      check(1, "claim after reset", bus_rdata, 16'h0001);
      @(negedge clk);
      idle();
      finish_run();
   end

endmodule